// File: doc/BRIEF.md
# Reset and HALT Wake-Up Sequencer

This block decides when a small processor core may run. It merges four causes of reset or wake-up: a power-on pulse, an active-low external reset pin, a watchdog expiry strobe and HALT wake-up events. From them it produces a full core reset, a stall, and a warm-reset strobe that clears only the program counter and the stack pointer. It keeps two status flags for software. The time-out flag (TO) records a watchdog expiry. The power-down flag (PD) records that the core went through HALT. Together the flags let firmware tell the cause of a restart.

When the core executes HALT, the block waits for a wake source. The sources are an enabled port pin stimulus, an interrupt request that was not already pending at HALT entry, a watchdog expiry or the reset pin. Every exit from reset or HALT runs through an internal start-up timer that holds the core for a fixed number of oscillator cycles. A two-bit wake code tells the core what to do when that hold ends: nothing, resume at the next instruction, take the interrupt, or restart. The `vector_go` strobe then marks the first free cycle of an interrupt wake.

Top module: `rst_wake_ctrl`

## Requirements
- R1: After a HALT wake-up or a watchdog reset taken in run, `core_stall` stays high for exactly SST_CYCLES cycles after the clock edge that saw the event. After `por_pulse` or the pin is released, `core_rst` stays high for SST_CYCLES+RST_SYNC_STAGES-1 cycles counted from the first edge that samples the pin high.
- R2: The status flags follow the reset cause. Power-on gives TO=0 and PD=0. A pin reset in run leaves both flags as they were. A pin reset during HALT gives TO=0 and PD=1. During any full reset, `core_rst`=1 and `wake_act`=3.
- R3: A watchdog strobe in run starts a full reset (`core_rst`=1, `wake_act`=3). It sets TO=1, leaves PD unchanged, and gives no `warm_rst`.
- R4: A watchdog strobe during HALT gives a one-cycle `warm_rst` pulse with `core_rst` held low. It sets TO=1 and PD=1, and `wake_act`=3.
- R5: A port stimulus on a pin whose wake enable is 1 wakes the core from HALT with `wake_act`=1 (next instruction). A stimulus on a pin whose enable is 0 leaves `halted`=1.
- R6: An interrupt wake gives `wake_act`=2 (vector) when at least one waking request is enabled and `stack_full`=0. Otherwise it gives `wake_act`=1.
- R7: An interrupt request already high when HALT is entered cannot wake the core until that request has been seen low for at least one cycle.
- R8: Entering HALT sets PD=1, TO=0 and `wake_act`=0, and raises `halted`. A watchdog-clear pulse in run sets TO=0 and PD=0.
- R9: When several wake causes meet at one edge, the order of precedence is pin reset, then watchdog, then interrupt, then port.
- R10: `vector_go` pulses for one cycle, in the first cycle with `core_stall`=0, and only when `wake_act`=2.
- R11: While the core is stalled by the start-up timer, `halt_req`, `wdt_clear` and `wdt_timeout` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_pulse | input | 1 | Power-on reset, active high, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous to clk |
| wdt_timeout | input | 1 | Watchdog expiry strobe |
| wdt_clear | input | 1 | Watchdog-clear instruction strobe |
| halt_req | input | 1 | HALT instruction strobe from the core |
| port_stim | input | NP | Per-pin wake stimulus from the port logic |
| port_wake_en | input | NP | Per-pin wake enable |
| irq_req | input | NI | Interrupt request flags |
| irq_en | input | NI | Interrupt enables |
| stack_full | input | 1 | Return stack has no free entry |
| core_rst | output | 1 | Full core reset |
| core_stall | output | 1 | Core may not execute |
| halted | output | 1 | Core is in HALT |
| warm_rst | output | 1 | One-cycle pulse that clears only the PC and SP |
| to_flag | output | 1 | Watchdog time-out status |
| pd_flag | output | 1 | Power-down status |
| wake_act | output | 2 | 0 none, 1 next instruction, 2 vector, 3 restart |
| vector_go | output | 1 | Interrupt response may start |

## Verification
Two collisions matter in HALT, and both are provoked on purpose. The first is a watchdog strobe that arrives on the same edge as an armed, enabled interrupt. The bench judges it by seeing `warm_rst` high and `wake_act`=3, with no vector. The second is a watchdog strobe placed exactly on the edge where the synchronised pin reset first takes effect. The bench counts the pin's synchroniser stages to find that edge. There it expects `core_rst`=1, no warm pulse, and TO=0 with PD=1. A port stimulus meeting an enabled interrupt is also driven, and must give the vector code.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
   typedef enum logic [1:0] {
      ST_SST  = 2'd0,
      ST_RUN  = 2'd1,
      ST_HALT = 2'd2
   } rwc_state_e;

   typedef enum logic [1:0] {
      WK_NONE    = 2'd0,
      WK_NEXT    = 2'd1,
      WK_VECTOR  = 2'd2,
      WK_RESTART = 2'd3
   } wake_code_e;
endpackage

// File: rtl/rwc_rst_sync.sv
module rwc_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por,
   input  logic pin_n,
   output logic rst_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rwc_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge por) begin
      if (por) chain <= '0;
      else     chain <= {chain[STAGES-2:0], pin_n};
   end

   assign rst_o = ~chain[STAGES-1];
endmodule

// File: rtl/rwc_sst_timer.sv
module rwc_sst_timer #(
   parameter int CYCLES = 1024
) (
   input  logic clk,
   input  logic por,
   input  logic clear,
   input  logic run,
   output logic last
);
   localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

   if (CYCLES < 2) begin : g_bad_cycles
      $error("rwc_sst_timer: CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign last = run && (cnt == CW'(CYCLES - 1));

   always_ff @(posedge clk or posedge por) begin
      if (por)        cnt <= '0;
      else if (clear) cnt <= '0;
      else if (run)   cnt <= last ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/rwc_wake_arb.sv
module rwc_wake_arb #(
   parameter int NP = 8,
   parameter int NI = 4
) (
   input  logic [NP-1:0] port_stim,
   input  logic [NP-1:0] port_wake_en,
   input  logic [NI-1:0] irq_req,
   input  logic [NI-1:0] irq_en,
   input  logic [NI-1:0] irq_block,
   input  logic          stack_full,
   output logic          irq_wake,
   output logic          irq_vector,
   output logic          port_wake
);
   logic [NI-1:0] armed;
   logic [NP-1:0] pin_hit;

   for (genvar g = 0; g < NI; g++) begin : g_irq
      assign armed[g] = irq_req[g] & ~irq_block[g];
   end
   for (genvar p = 0; p < NP; p++) begin : g_pin
      assign pin_hit[p] = port_stim[p] & port_wake_en[p];
   end

   assign irq_wake   = |armed;
   assign irq_vector = (|(armed & irq_en)) & ~stack_full;
   assign port_wake  = |pin_hit;
endmodule

// File: rtl/rst_wake_ctrl.sv
module rst_wake_ctrl
   import rwc_pkg::*;
#(
   parameter int SST_CYCLES      = 1024,
   parameter int RST_SYNC_STAGES = 2,
   parameter int NP              = 8,
   parameter int NI              = 4
) (
   input  logic          clk,
   input  logic          por_pulse,
   input  logic          rst_pin_n,
   input  logic          wdt_timeout,
   input  logic          wdt_clear,
   input  logic          halt_req,
   input  logic [NP-1:0] port_stim,
   input  logic [NP-1:0] port_wake_en,
   input  logic [NI-1:0] irq_req,
   input  logic [NI-1:0] irq_en,
   input  logic          stack_full,
   output logic          core_rst,
   output logic          core_stall,
   output logic          halted,
   output logic          warm_rst,
   output logic          to_flag,
   output logic          pd_flag,
   output logic [1:0]    wake_act,
   output logic          vector_go
);
   if (NP < 1 || NI < 1) begin : g_bad_width
      $error("rst_wake_ctrl: NP and NI must be at least 1");
   end

   rwc_state_e    state;
   wake_code_e    code_q;
   logic          full_rst, warm_q, to_q, pd_q, vec_q;
   logic [NI-1:0] irq_block;
   logic          rst_int, sst_last, irq_wake, irq_vector, port_wake;

   rwc_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_sync (
      .clk   (clk),
      .por   (por_pulse),
      .pin_n (rst_pin_n),
      .rst_o (rst_int)
   );

   rwc_sst_timer #(.CYCLES(SST_CYCLES)) u_sst (
      .clk   (clk),
      .por   (por_pulse),
      .clear (rst_int || (state != ST_SST)),
      .run   (state == ST_SST),
      .last  (sst_last)
   );

   rwc_wake_arb #(.NP(NP), .NI(NI)) u_arb (
      .port_stim    (port_stim),
      .port_wake_en (port_wake_en),
      .irq_req      (irq_req),
      .irq_en       (irq_en),
      .irq_block    (irq_block),
      .stack_full   (stack_full),
      .irq_wake     (irq_wake),
      .irq_vector   (irq_vector),
      .port_wake    (port_wake)
   );

   always_ff @(posedge clk or posedge por_pulse) begin
      if (por_pulse) begin
         state     <= ST_SST;
         full_rst  <= 1'b1;
         warm_q    <= 1'b0;
         to_q      <= 1'b0;
         pd_q      <= 1'b0;
         code_q    <= WK_RESTART;
         vec_q     <= 1'b0;
         irq_block <= '0;
      end else begin
         warm_q <= 1'b0;
         vec_q  <= 1'b0;
         if (rst_int) begin
            if (state == ST_HALT) begin
               to_q <= 1'b0;
               pd_q <= 1'b1;
            end
            state     <= ST_SST;
            full_rst  <= 1'b1;
            code_q    <= WK_RESTART;
            irq_block <= '0;
         end else begin
            case (state)
               ST_RUN: begin
                  if (wdt_timeout) begin
                     to_q     <= 1'b1;
                     state    <= ST_SST;
                     full_rst <= 1'b1;
                     code_q   <= WK_RESTART;
                  end else if (halt_req) begin
                     state     <= ST_HALT;
                     pd_q      <= 1'b1;
                     to_q      <= 1'b0;
                     code_q    <= WK_NONE;
                     irq_block <= irq_req;
                  end else if (wdt_clear) begin
                     to_q <= 1'b0;
                     pd_q <= 1'b0;
                  end
               end
               ST_HALT: begin
                  irq_block <= irq_block & irq_req;
                  if (wdt_timeout) begin
                     to_q   <= 1'b1;
                     pd_q   <= 1'b1;
                     warm_q <= 1'b1;
                     state  <= ST_SST;
                     code_q <= WK_RESTART;
                  end else if (irq_wake) begin
                     state  <= ST_SST;
                     code_q <= irq_vector ? WK_VECTOR : WK_NEXT;
                  end else if (port_wake) begin
                     state  <= ST_SST;
                     code_q <= WK_NEXT;
                  end
               end
               default: begin
                  if (sst_last) begin
                     state    <= ST_RUN;
                     full_rst <= 1'b0;
                     vec_q    <= (code_q == WK_VECTOR);
                  end
               end
            endcase
         end
      end
   end

   assign core_rst   = full_rst;
   assign core_stall = (state != ST_RUN);
   assign halted     = (state == ST_HALT);
   assign warm_rst   = warm_q;
   assign to_flag    = to_q;
   assign pd_flag    = pd_q;
   assign wake_act   = code_q;
   assign vector_go  = vec_q;

   AST_RST_HOLDS_STALL: assert property (@(posedge clk) disable iff (por_pulse)
      core_rst |-> core_stall);                                          // R1
   AST_WARM_FROM_HALT: assert property (@(posedge clk) disable iff (por_pulse)
      warm_rst |-> ($past(state == ST_HALT) && !core_rst));              // R4
   AST_WARM_SINGLE: assert property (@(posedge clk) disable iff (por_pulse)
      warm_rst |=> !warm_rst);                                           // R4
   AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (por_pulse)
      halted |-> (pd_flag && !to_flag));                                 // R8
   AST_VEC_FIRST_FREE: assert property (@(posedge clk) disable iff (por_pulse)
      vector_go |-> (!core_stall && $past(core_stall)));                 // R10
   AST_VEC_CODE: assert property (@(posedge clk) disable iff (por_pulse)
      vector_go |-> (wake_act == WK_VECTOR));                            // R6
   AST_HALT_ONLY_FROM_RUN: assert property (@(posedge clk) disable iff (por_pulse)
      $rose(halted) |-> $past(state == ST_RUN));                         // R11
endmodule

// File: tb/rst_wake_ctrl_test.sv
module rst_wake_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int SST = 1024;
   localparam int SYNC = 2;
   localparam int NP = 8;
   localparam int NI = 4;
   localparam int NV = 8;

   // {wdt, irq[4], en[4], sf, stim[8], pen[8], wake, code[2], warm, to, pd}
   localparam logic [31:0] VEC [0:NV-1] = '{
      {1'b0, 4'h0, 4'h0, 1'b0, 8'h08, 8'h08, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1},
      {1'b0, 4'h1, 4'h1, 1'b0, 8'h00, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1},
      {1'b0, 4'h2, 4'h1, 1'b0, 8'h00, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1},
      {1'b0, 4'h4, 4'h4, 1'b1, 8'h00, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1},
      {1'b1, 4'h0, 4'h0, 1'b0, 8'h00, 8'h00, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1},
      {1'b0, 4'h0, 4'h0, 1'b0, 8'h20, 8'h01, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1},
      {1'b1, 4'h1, 4'h1, 1'b0, 8'h00, 8'h00, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1},
      {1'b0, 4'h8, 4'h8, 1'b0, 8'h01, 8'h01, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1}
   };

   logic          clk = 1'b0;
   logic          por_pulse = 1'b1;
   logic          rst_pin_n = 1'b1;
   logic          wdt_timeout = 1'b0, wdt_clear = 1'b0, halt_req = 1'b0;
   logic [NP-1:0] port_stim = '0, port_wake_en = '0;
   logic [NI-1:0] irq_req = '0, irq_en = '0;
   logic          stack_full = 1'b0;
   logic          core_rst, core_stall, halted, warm_rst, to_flag, pd_flag, vector_go;
   logic [1:0]    wake_act;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rst_wake_ctrl #(.SST_CYCLES(SST), .RST_SYNC_STAGES(SYNC), .NP(NP), .NI(NI)) uut (
      .clk(clk), .por_pulse(por_pulse), .rst_pin_n(rst_pin_n),
      .wdt_timeout(wdt_timeout), .wdt_clear(wdt_clear), .halt_req(halt_req),
      .port_stim(port_stim), .port_wake_en(port_wake_en),
      .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
      .core_rst(core_rst), .core_stall(core_stall), .halted(halted),
      .warm_rst(warm_rst), .to_flag(to_flag), .pd_flag(pd_flag),
      .wake_act(wake_act), .vector_go(vector_go)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_stall(output int n);
      n = 0;
      while (core_stall && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic count_rst(output int n);
      n = 0;
      while (core_rst && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic enter_halt();
      halt_req = 1'b1;
      @(negedge clk);
      halt_req = 1'b0;
      chk("R8 halted", halted, 1);
      chk("R8 pd on halt", pd_flag, 1);
      chk("R8 to on halt", to_flag, 0);
      chk("R8 code on halt", wake_act, 0);
   endtask

   function automatic string tag_of(input int i);
      case (i)
         0: return "R5 port wake";
         1: return "R6 irq vector";
         2: return "R6 irq disabled";
         3: return "R6 stack full";
         4: return "R4 warm reset";
         5: return "R5 pin not enabled";
         6: return "R9 wdt over irq";
         default: return "R9 irq over port";
      endcase
   endfunction

   initial begin
      int n;
      logic [31:0] v;
      repeat (3) @(negedge clk);
      chk("R2 por core_rst", core_rst, 1);
      chk("R2 por stall", core_stall, 1);
      chk("R2 por to", to_flag, 0);
      chk("R2 por pd", pd_flag, 0);
      chk("R2 por code", wake_act, 3);
      chk("R4 por warm", warm_rst, 0);
      por_pulse = 1'b0;
      @(negedge clk);
      count_rst(n);
      chk("R1 por release length", n, SST + SYNC - 1);
      chk("R1 running", core_stall, 0);

      // table walk of HALT wake cases
      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         enter_halt();
         wdt_timeout  = v[31];
         irq_req      = v[30:27];
         irq_en       = v[26:23];
         stack_full   = v[22];
         port_stim    = v[21:14];
         port_wake_en = v[13:6];
         @(negedge clk);
         wdt_timeout = 1'b0; irq_req = '0; irq_en = '0; stack_full = 1'b0;
         port_stim = '0; port_wake_en = '0;
         chk(tag_of(i), halted, v[5] ? 0 : 1);
         chk(tag_of(i), wake_act, v[4:3]);
         chk(tag_of(i), warm_rst, v[2]);
         chk(tag_of(i), to_flag, v[1]);
         chk(tag_of(i), pd_flag, v[0]);
         chk(tag_of(i), core_rst, 0);
         if (!v[5]) begin
            repeat (3) @(negedge clk);
            chk("R5 still halted", halted, 1);
            port_stim = 8'h01; port_wake_en = 8'h01;
            @(negedge clk);
            port_stim = '0; port_wake_en = '0;
            chk("R5 enabled pin wakes", wake_act, 1);
         end
         if (v[2]) begin
            @(negedge clk);
            chk("R4 warm single", warm_rst, 0);
            count_stall(n);
            chk("R1 stall after warm", n, SST - 1);
         end else begin
            count_stall(n);
            chk("R1 stall after wake", n, SST);
         end
         chk("R10 vector_go", vector_go, (v[4:3] == 2'd2) ? 1 : 0);
         @(negedge clk);
         chk("R10 vector_go single", vector_go, 0);
      end

      // pin reset during run keeps flags (to0 pd1 from last wake)
      rst_pin_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R2 pin run core_rst", core_rst, 1);
      chk("R2 pin run to kept", to_flag, 0);
      chk("R2 pin run pd kept", pd_flag, 1);
      chk("R2 pin run code", wake_act, 3);
      rst_pin_n = 1'b1;
      @(negedge clk);
      count_rst(n);
      chk("R1 pin release length", n, SST + SYNC - 1);

      // watchdog during run
      wdt_timeout = 1'b1;
      @(negedge clk);
      wdt_timeout = 1'b0;
      chk("R3 wdt run core_rst", core_rst, 1);
      chk("R3 wdt run to", to_flag, 1);
      chk("R3 wdt run pd kept", pd_flag, 1);
      chk("R3 wdt run warm", warm_rst, 0);
      chk("R3 wdt run code", wake_act, 3);
      count_rst(n);
      chk("R1 wdt run length", n, SST);

      // watchdog clear in run
      wdt_clear = 1'b1;
      @(negedge clk);
      wdt_clear = 1'b0;
      chk("R8 clear to", to_flag, 0);
      chk("R8 clear pd", pd_flag, 0);

      // pin reset during HALT
      enter_halt();
      wdt_clear = 1'b1;   // make PD observable: clear must not act in HALT
      rst_pin_n = 1'b0;
      @(negedge clk);
      wdt_clear = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 pin halt core_rst", core_rst, 1);
      chk("R2 pin halt halted", halted, 0);
      chk("R2 pin halt to", to_flag, 0);
      chk("R2 pin halt pd", pd_flag, 1);
      rst_pin_n = 1'b1;
      @(negedge clk);
      count_rst(n);
      chk("R1 pin halt release", n, SST + SYNC - 1);

      // pin reset and watchdog on the same effective edge in HALT
      enter_halt();
      rst_pin_n = 1'b0;
      repeat (2) @(negedge clk);
      wdt_timeout = 1'b1;
      @(negedge clk);
      wdt_timeout = 1'b0;
      chk("R9 pin over wdt core_rst", core_rst, 1);
      chk("R9 pin over wdt warm", warm_rst, 0);
      chk("R9 pin over wdt to", to_flag, 0);
      chk("R9 pin over wdt pd", pd_flag, 1);
      rst_pin_n = 1'b1;
      @(negedge clk);
      count_rst(n);
      chk("R1 release after collision", n, SST + SYNC - 1);

      // interrupt pending at HALT entry is blocked
      irq_req = 4'b0010; irq_en = 4'b0010; halt_req = 1'b1;
      @(negedge clk);
      halt_req = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7 pending irq blocked", halted, 1);
      irq_req = '0;
      @(negedge clk);
      chk("R7 low request no wake", halted, 1);
      irq_req = 4'b0010;
      @(negedge clk);
      irq_req = '0; irq_en = '0;
      chk("R7 re-raised irq wakes", halted, 0);
      chk("R7 re-raised code", wake_act, 2);
      count_stall(n);
      chk("R1 stall after irq", n, SST);
      chk("R10 vector after stall", vector_go, 1);
      @(negedge clk);
      chk("R10 vector single", vector_go, 0);

      // strobes ignored while stalled
      enter_halt();
      port_stim = 8'h01; port_wake_en = 8'h01;
      @(negedge clk);
      port_stim = '0; port_wake_en = '0;
      halt_req = 1'b1; wdt_clear = 1'b1; wdt_timeout = 1'b1;
      @(negedge clk);
      halt_req = 1'b0; wdt_clear = 1'b0; wdt_timeout = 1'b0;
      count_stall(n);
      chk("R11 stall length kept", n, SST - 1);
      chk("R11 not halted", halted, 0);
      chk("R11 no reset", core_rst, 0);
      chk("R11 pd kept", pd_flag, 1);
      chk("R11 to kept", to_flag, 0);
      chk("R11 code kept", wake_act, 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule